// File: doc/BRIEF.md
# Dual-Mode Serial Frame Receiver

This block receives 10-bit update words for a four-channel converter over a serial clock line and a serial data line. Each word carries a 2-bit channel address followed by an 8-bit value. Both lines are sampled by a much faster system clock: each passes through a two-flop synchronizer, and its edges are found in the system-clock domain. Bits are taken on each falling edge of the serial clock. When a word is complete, the block raises a one-cycle transfer pulse and holds the address and value on its outputs.

A mode input picks one of two ways to mark word boundaries. In strobe framing, a falling edge on an active-low load line ends the word, and the transfer uses the last ten bits shifted in. In edge framing, the load line is ignored and the boundaries are encoded on the two lines themselves. A start is data falling while the clock is high, followed by the clock falling, and that clock fall always shifts in a 0. A stop is the clock rising while data is low, followed by data rising while the clock stays high. The stop ends the word and triggers the transfer. The mode is taken in only while the interface is idle.

A serial cascade output carries the oldest bit of the shift path, so a second receiver can be chained behind the first. In edge framing the path is one bit longer, to hold the start bit. In a chained edge-framed burst, words are separated by a single 0 bit and one stop is sent after the last word, so each receiver presents only the final ten bits it holds.

Top module: `serframe_rx`

## Requirements
- R1: Bits are captured on each falling edge of the serial clock, and a word is sent in this order: address MSB, address LSB, then value bits 7 down to 0. The first two bits of a word therefore appear on `xfer_addr` with the first bit as bit 1, and the following eight bits appear on `xfer_data` with the first of them as bit 7.
- R2: In strobe framing (mode input 0), a falling edge of `load_n` raises `xfer_pulse` and presents the last ten bits captured, as laid out in R1.
- R3: `xfer_pulse` is never high on two consecutive system-clock cycles, and each completed word raises it exactly once.
- R4: In edge framing (mode input 1), a start followed by ten bits and a stop raises `xfer_pulse` with the ten bits that came after the start bit.
- R5: In edge framing, a stop that arrives after fewer than ten bits following the start bit raises no pulse.
- R6: In edge framing, a burst of a start, a first word, one 0 separator bit, a second word and one stop produces exactly one pulse, and it carries the second word.
- R7: `cascade_out` equals the bit captured ten clock falls earlier in strobe framing, and eleven clock falls earlier in edge framing. So after a start and ten bits it is 0, and after one more fall it is the first bit of the word.
- R8: Each framing ignores the other's boundary marks. In edge framing a falling edge on `load_n` raises no pulse. In strobe framing a data fall and rise while the clock is high raises no pulse.
- R9: The mode input is taken in only when both lines are high and no word is in progress. A change of the mode input in the middle of a word leaves the current framing in force until that word completes.
- R10: After reset, `xfer_pulse`, `xfer_addr`, `xfer_data` and `cascade_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| two_wire_mode | input | 1 | Framing select: 1 for edge framing, 0 for strobe framing |
| sclk_in | input | 1 | Serial clock line, asynchronous |
| sdat_in | input | 1 | Serial data line, asynchronous |
| load_n | input | 1 | Active-low load strobe, used in strobe framing only |
| cascade_out | output | 1 | Oldest bit of the shift path, for chaining a further receiver |
| xfer_pulse | output | 1 | One-cycle pulse when a word is presented |
| xfer_addr | output | 2 | Channel address of the presented word |
| xfer_data | output | 8 | Value of the presented word |

## Verification
The hardest case to reach from the ports is a stop that is judged against the number of bits received. This covers a stop that comes too early, and a chained burst in which more than ten bits sit behind a single start. The bench builds these cases from tasks that drive a start, single bits, a separator bit and a stop as separate line sequences. Short frames of five and nine bits and a two-word burst then come from the same pieces. Mode changes are made inside an open edge-framed word and at idle, which shows when the mode input is taken in.

// File: rtl/serframe_rx.sv
module serframe_rx #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_wire_mode,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic              load_n,
  output logic              cascade_out,
  output logic              xfer_pulse,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [DATA_W-1:0] xfer_data
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int SR_W    = FRAME_W + 1;
  localparam int CNT_W   = $clog2(SR_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SR_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_FRAME} tw_state_t;

  logic [1:0] sck_sy, sda_sy, ld_sy;
  logic       sck_d, sda_d, ld_d;
  logic       mode_q;
  tw_state_t  st;
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;

  wire sck = sck_sy[1];
  wire sda = sda_sy[1];
  wire ld  = ld_sy[1];

  wire sck_fall = sck_d & ~sck;
  wire ld_fall  = ld_d & ~ld;
  wire sda_fall = sda_d & ~sda & sck & sck_d;
  wire sda_rise = ~sda_d & sda & sck & sck_d;

  wire busy = mode_q ? (st != ST_IDLE) : (cnt != '0);
  wire idle = sck & sda & ~busy;

  wire shift_en = sck_fall & (~mode_q | (st != ST_IDLE));
  wire bit_in   = (mode_q && st == ST_ARMED) ? 1'b0 : sda;
  wire strobe_x = ~mode_q & ld_fall;
  wire stop_x   = mode_q & (st == ST_FRAME) & sda_rise;
  wire take     = strobe_x | (stop_x & (cnt >= CNT_FULL));

  wire [CNT_W-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  assign cascade_out = mode_q ? sr[SR_W-1] : sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= 2'b11;
      sda_sy <= 2'b11;
      ld_sy  <= 2'b11;
      sck_d  <= 1'b1;
      sda_d  <= 1'b1;
      ld_d   <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[0], sclk_in};
      sda_sy <= {sda_sy[0], sdat_in};
      ld_sy  <= {ld_sy[0], load_n};
      sck_d  <= sck;
      sda_d  <= sda;
      ld_d   <= ld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (idle) mode_q <= two_wire_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (shift_en) begin
      sr <= {sr[SR_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (idle && (two_wire_mode != mode_q)) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!mode_q) begin
      st <= ST_IDLE;
      if (strobe_x) cnt <= '0;
      else if (sck_fall) cnt <= cnt_inc;
    end else begin
      case (st)
        ST_IDLE: if (sda_fall) st <= ST_ARMED;
        ST_ARMED: begin
          if (sda_rise) st <= ST_IDLE;
          else if (sck_fall) begin
            st  <= ST_FRAME;
            cnt <= '0;
          end
        end
        ST_FRAME: begin
          if (sda_rise) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else if (sda_fall) st <= ST_ARMED;
          else if (sck_fall) cnt <= cnt_inc;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_pulse <= 1'b0;
      xfer_addr  <= '0;
      xfer_data  <= '0;
    end else begin
      xfer_pulse <= take;
      if (take) begin
        xfer_addr <= sr[FRAME_W-1 -: ADDR_W];
        xfer_data <= sr[DATA_W-1:0];
      end
    end
  end

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |=> !xfer_pulse);

  // R5
  short_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && $past(mode_q)) |-> ($past(cnt) >= CNT_FULL));

  // R8
  edge_mode_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !(st == ST_FRAME && sda_rise)) |=> !xfer_pulse);

  // R4
  start_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && st == ST_ARMED && sck_fall && !sda_rise) |=> (sr[0] == 1'b0 && cnt == '0));

  // R7
  cascade_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !mode_q) |=> (cascade_out == $past(sr[FRAME_W-2])));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !idle) |=> $stable(mode_q));
endmodule

// File: tb/serframe_rx_bench.sv
module serframe_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_wire_mode = 1'b0;
  logic sclk_in = 1'b1;
  logic sdat_in = 1'b1;
  logic load_n = 1'b1;
  logic cascade_out, xfer_pulse;
  logic [1:0] xfer_addr;
  logic [7:0] xfer_data;

  int checks = 0;
  int fails = 0;
  int npulse = 0;
  int wide = 0;
  logic prev_pulse = 1'b0;
  logic [9:0] cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serframe_rx u_serframe_rx (
    .clk(clk), .rst_n(rst_n), .two_wire_mode(two_wire_mode),
    .sclk_in(sclk_in), .sdat_in(sdat_in), .load_n(load_n),
    .cascade_out(cascade_out), .xfer_pulse(xfer_pulse),
    .xfer_addr(xfer_addr), .xfer_data(xfer_data)
  );

  always @(negedge clk) begin
    if (xfer_pulse) begin
      npulse = npulse + 1;
      cap = {xfer_addr, xfer_data};
    end
    if (xfer_pulse && prev_pulse) wide = wide + 1;
    prev_pulse = xfer_pulse;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit3(input logic b);
    sdat_in = b; wt(4);
    sclk_in = 1'b0; wt(4);
    sclk_in = 1'b1;
  endtask

  task automatic frame3_bits(input logic [9:0] w);
    for (int k = 9; k >= 0; k--) bit3(w[k]);
  endtask

  task automatic strobe3;
    wt(4);
    load_n = 1'b0; wt(4);
    load_n = 1'b1; sdat_in = 1'b1; wt(6);
  endtask

  task automatic start2;
    sdat_in = 1'b0; wt(4);
    sclk_in = 1'b0; wt(4);
  endtask

  task automatic bit2(input logic b);
    sdat_in = b; wt(2);
    sclk_in = 1'b1; wt(4);
    sclk_in = 1'b0; wt(4);
  endtask

  task automatic stop2;
    sdat_in = 1'b0; wt(2);
    sclk_in = 1'b1; wt(4);
    sdat_in = 1'b1; wt(8);
  endtask

  function automatic logic [9:0] word_of(input int i);
    logic [7:0] d;
    d = 8'((i * 53 + 17) & 255);
    return {2'(i & 3), d};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    logic [9:0] w, w2;
    wt(3);
    chk(xfer_pulse == 0 && xfer_addr == 0 && xfer_data == 0 && cascade_out == 0,
        "R10 reset outputs", {xfer_pulse, xfer_addr, xfer_data, cascade_out}, 0);
    rst_n = 1'b1;
    wt(6);
    chk(xfer_pulse == 0 && npulse == 0, "R10 idle after reset", npulse, 0);

    for (int i = 0; i < 256; i++) begin
      w = word_of(i);
      p0 = npulse;
      frame3_bits(w);
      chk(cascade_out == w[9], "R7 strobe cascade", cascade_out, w[9]);
      strobe3();
      chk(npulse == p0 + 1, "R2 strobe pulse", npulse - p0, 1);
      chk(cap == w, "R1 strobe word", cap, w);
    end

    p0 = npulse;
    bit3(1'b1); bit3(1'b0); frame3_bits(10'h2C5);
    strobe3();
    chk(cap == 10'h2C5 && npulse == p0 + 1, "R2 last ten bits", cap, 10'h2C5);

    p0 = npulse;
    sdat_in = 1'b0; wt(6); sdat_in = 1'b1; wt(8);
    chk(npulse == p0, "R8 strobe mode ignores data edges", npulse - p0, 0);

    two_wire_mode = 1'b1; wt(8);
    p0 = npulse;
    load_n = 1'b0; wt(6); load_n = 1'b1; wt(8);
    chk(npulse == p0, "R8 edge mode ignores load", npulse - p0, 0);

    for (int i = 0; i < 128; i++) begin
      w = word_of(i * 2 + 1);
      p0 = npulse;
      start2();
      for (int k = 9; k >= 0; k--) bit2(w[k]);
      chk(cascade_out == 1'b0, "R7 edge cascade start bit", cascade_out, 0);
      stop2();
      chk(npulse == p0 + 1, "R4 edge pulse", npulse - p0, 1);
      chk(cap == w, "R4 edge word", cap, w);
    end

    p0 = npulse;
    start2();
    for (int k = 0; k < 5; k++) bit2(k[0]);
    stop2();
    chk(npulse == p0, "R5 five-bit frame", npulse - p0, 0);
    start2();
    for (int k = 0; k < 9; k++) bit2(1'b1);
    stop2();
    chk(npulse == p0, "R5 nine-bit frame", npulse - p0, 0);

    w = 10'h1A7; w2 = 10'h35C;
    p0 = npulse;
    start2();
    for (int k = 9; k >= 0; k--) bit2(w[k]);
    bit2(1'b0);
    chk(cascade_out == w[9], "R7 edge cascade first bit", cascade_out, w[9]);
    for (int k = 9; k >= 0; k--) bit2(w2[k]);
    stop2();
    chk(npulse == p0 + 1, "R6 burst single pulse", npulse - p0, 1);
    chk(cap == w2, "R6 burst last word", cap, w2);

    w = 10'h0F3;
    p0 = npulse;
    start2();
    for (int k = 9; k >= 5; k--) bit2(w[k]);
    two_wire_mode = 1'b0;
    for (int k = 4; k >= 0; k--) bit2(w[k]);
    stop2();
    chk(npulse == p0 + 1 && cap == w, "R9 mode held mid-frame", cap, w);
    wt(6);
    w = 10'h2E1;
    p0 = npulse;
    frame3_bits(w);
    strobe3();
    chk(npulse == p0 + 1 && cap == w, "R9 mode taken at idle", cap, w);

    chk(wide == 0, "R3 pulse width", wide, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule